// File: doc/BRIEF.md
# Multiplexed-address flash bus front end

This block sits between the pins of a parallel programming port and the core of a byte-wide flash memory. The external address bus is only half as wide as the memory address. The programmer first presents the row half and drops the row/column strobe, then presents the column half and raises the strobe. The block joins the two halves into one full address. It also decodes the output-enable, write-enable and active-low interface-reset pins into bus read, bus write, output disable and reset.

All pins are sampled into the block clock through a synchronizer of `SYNC_STAGES` flops. A rising write-enable edge hands the data byte and the full address to the command logic over a valid/ready port. A read drives the data bus from one of three sources, chosen by the command logic: the array port, the status port, or a built-in identifier. The identifier returns fixed maker and device bytes and always reports the blocks as unprotected. An interface reset held low long enough returns the block to its reset state. If the command logic is busy at that point, the block also raises an abort, which flags the last forwarded address as holding invalid data.

The command port follows valid/ready rules. `cmd_valid` stays high, with `cmd_data` and `cmd_addr` held stable, until the cycle in which `cmd_ready` is high. A new write that arrives while the slot is still occupied and not being accepted is discarded. A write that arrives in the same cycle as an accepted transfer refills the slot.

Top module: `mux_flash_front`

## Requirements
- R1: A falling edge of `pin_rc` loads `pin_addr` as the row half. A rising edge loads it as the column half. Both are ignored while the interface reset is low. `arr_addr` carries the row in bits 10:0 and the column in bits 21:11.
- R2: When the synchronized pins show reset high, write-enable high and output-enable low, `dq_oe` is 1 and `dq_o` carries the selected byte for the current full address. The data bus reflects pin state `SYNC_STAGES`+1 clock edges after the pins are first sampled.
- R3: While output-enable is high, `dq_oe` is 0 and `dq_o` is 0x00, whatever the state of write-enable. With output-enable and write-enable both low, `dq_oe` is also 0.
- R4: While `pin_ifc_rst_n` is low, `dq_oe` is 0, whatever the states of output-enable and write-enable.
- R5: A rising edge of write-enable, seen with output-enable high and reset high, loads the data byte and the current full address into the command slot. `cmd_valid` then goes high. A write-enable rising edge seen with output-enable low is ignored.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data` and `cmd_addr` hold. A write arriving in that state is discarded.
- R7: A cycle with `src_load` high sets the read source from `src_code`: 0 selects the array, 1 the status port and 2 the identifier. Code 3 is ignored. After `rst_n` the source is the array.
- R8: In identifier mode, a full address with bit 1 low returns 0x20 when bit 0 is 0 and 0x29 when bit 0 is 1. A full address with bit 1 high returns 0x00, meaning every block is unprotected.
- R9: An interface reset low for fewer than `RST_MIN` consecutive cycles leaves the read source, the full address and a pending command unchanged.
- R10: An interface reset low for `RST_MIN` cycles qualifies as a reset. It sets the read source to the array, clears the full address to 0 and drops a pending command.
- R11: When a reset qualifies while `op_busy` is high, `op_abort` pulses high for exactly one cycle. `abort_addr` then shows the address of the last command loaded into the slot. A reset that qualifies with `op_busy` low raises no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_addr | input | 11 | Shared row/column address pins |
| pin_rc | input | 1 | Row/column strobe (fall = row, rise = column) |
| pin_oe_n | input | 1 | Active-low output enable |
| pin_we_n | input | 1 | Active-low write enable |
| pin_ifc_rst_n | input | 1 | Active-low interface reset |
| dq_i | input | 8 | Data bus, input side |
| dq_o | output | 8 | Data bus, output side |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| cmd_valid | output | 1 | Command slot holds a written byte |
| cmd_ready | input | 1 | Command logic accepts the slot this cycle |
| cmd_data | output | 8 | Written byte |
| cmd_addr | output | 22 | Full address of the written byte |
| src_load | input | 1 | Load a new read source |
| src_code | input | 2 | Read source code |
| arr_addr | output | 22 | Full address toward the array |
| arr_rdata | input | 8 | Array byte at `arr_addr` |
| stat_data | input | 8 | Status byte |
| op_busy | input | 1 | Program or erase in progress |
| op_abort | output | 1 | One-cycle abort of the running operation |
| abort_addr | output | 22 | Address flagged as invalid by the abort |

## Verification
A wrong row or column register shows on `arr_addr` one edge after the strobe edge is synchronized. It also shows in every following read byte. A wrong read source or a wrong identifier decode shows on `dq_o` at the first read, `SYNC_STAGES`+1 edges after output-enable falls. A miscounted reset qualifier shows in one of two ways: an abort that fires a cycle early or late, or a cleared address after a reset that was too short. Both appear at `op_abort` and `arr_addr` right after the reset pulse, so a per-clock comparison against a reference model catches each fault in the cycle it occurs.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_SIG    = 2'd2,
    SRC_RSVD   = 2'd3
  } rd_src_e;

  localparam logic [7:0] ID_MAKER   = 8'h20;
  localparam logic [7:0] ID_DEVICE  = 8'h29;
  localparam logic [7:0] LOCK_CLEAR = 8'h00;

  // identifier byte: bit 1 picks the lock query, bit 0 maker/device
  function automatic logic [7:0] sig_byte(input logic a1, input logic a0);
    if (a1) return LOCK_CLEAR;
    return a0 ? ID_DEVICE : ID_MAKER;
  endfunction

endpackage

// File: rtl/mfb_sync.sv
module mfb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mfb_addr_latch.sv
module mfb_addr_latch #(
  parameter int PW = 11,
  localparam int FW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rc_s,
  input  logic [PW-1:0] addr_s,
  input  logic          live,
  input  logic          clr,
  output logic [FW-1:0] full_addr
);

  logic          rc_q;
  logic [PW-1:0] row_q;
  logic [PW-1:0] col_q;
  logic          rc_fall;
  logic          rc_rise;

  assign rc_fall = rc_q & ~rc_s;
  assign rc_rise = ~rc_q & rc_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= 1'b1;
      row_q <= '0;
      col_q <= '0;
    end else begin
      rc_q <= rc_s;
      if (clr) begin
        row_q <= '0;
        col_q <= '0;
      end else if (live) begin
        if (rc_fall) row_q <= addr_s;
        if (rc_rise) col_q <= addr_s;
      end
    end
  end

  assign full_addr = {col_q, row_q};

endmodule

// File: rtl/mfb_rst_qual.sv
module mfb_rst_qual #(
  parameter int RST_MIN = 8,
  localparam int CW = $clog2(RST_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irst_n_s,
  output logic fire
);

  localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);
  localparam logic [CW-1:0] CAP  = CW'(RST_MIN);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (irst_n_s) begin
      low_cnt <= '0;
    end else if (low_cnt != CAP) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // fires once, on the cycle the low run reaches the minimum width
  assign fire = ~irst_n_s & (low_cnt == LAST);

endmodule

// File: rtl/mfb_wr_port.sv
module mfb_wr_port #(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n_s,
  input  logic          oe_n_s,
  input  logic          live,
  input  logic [DW-1:0] dq_s,
  input  logic [AW-1:0] cur_addr,
  input  logic          clr,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  output logic [AW-1:0] cmd_addr
);

  logic we_q;
  logic strobe;
  logic slot_free;

  assign strobe    = ~we_q & we_n_s & oe_n_s & live;
  assign slot_free = ~cmd_valid | cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      cmd_addr  <= '0;
    end else begin
      we_q <= we_n_s;
      if (clr) begin
        cmd_valid <= 1'b0;
      end else if (strobe && slot_free) begin
        cmd_valid <= 1'b1;
        cmd_data  <= dq_s;
        cmd_addr  <= cur_addr;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mfb_rd_path.sv
module mfb_rd_path
  import mfb_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_load,
  input  logic [1:0]    src_code,
  input  logic          clr,
  input  logic          read_en,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] stat_data,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);

  rd_src_e       sel_q;
  logic [DW-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_ARRAY;
    end else if (clr) begin
      sel_q <= SRC_ARRAY;
    end else if (src_load && (rd_src_e'(src_code) != SRC_RSVD)) begin
      sel_q <= rd_src_e'(src_code);
    end
  end

  always_comb begin
    case (sel_q)
      SRC_STATUS: pick = stat_data;
      SRC_SIG:    pick = DW'(sig_byte(cur_addr[1], cur_addr[0]));
      default:    pick = arr_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe <= 1'b0;
      dq_o  <= '0;
    end else begin
      dq_oe <= read_en;
      dq_o  <= read_en ? pick : '0;
    end
  end

endmodule

// File: rtl/mux_flash_front.sv
module mux_flash_front #(
  parameter int PIN_AW      = 11,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_MIN     = 8,
  localparam int FULL_AW    = 2 * PIN_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_AW-1:0]  pin_addr,
  input  logic               pin_rc,
  input  logic               pin_oe_n,
  input  logic               pin_we_n,
  input  logic               pin_ifc_rst_n,
  input  logic [DW-1:0]      dq_i,
  output logic [DW-1:0]      dq_o,
  output logic               dq_oe,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [DW-1:0]      cmd_data,
  output logic [FULL_AW-1:0] cmd_addr,
  input  logic               src_load,
  input  logic [1:0]         src_code,
  output logic [FULL_AW-1:0] arr_addr,
  input  logic [DW-1:0]      arr_rdata,
  input  logic [DW-1:0]      stat_data,
  input  logic               op_busy,
  output logic               op_abort,
  output logic [FULL_AW-1:0] abort_addr
);

  localparam int PV_W = PIN_AW + DW + 4;
  localparam logic [PV_W-1:0] PV_IDLE = PV_W'(4'hF);

  logic [PV_W-1:0]   pv_raw;
  logic [PV_W-1:0]   pv_s;
  logic [PIN_AW-1:0] addr_s;
  logic [DW-1:0]     dq_s;
  logic              rc_s;
  logic              oe_n_s;
  logic              we_n_s;
  logic              irst_s;
  logic              rst_fire;
  logic              read_en;

  assign pv_raw = {pin_addr, dq_i, pin_rc, pin_oe_n, pin_we_n, pin_ifc_rst_n};

  mfb_sync #(.W(PV_W), .STAGES(SYNC_STAGES), .RST_VAL(PV_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pv_raw),
    .q     (pv_s)
  );

  assign {addr_s, dq_s, rc_s, oe_n_s, we_n_s, irst_s} = pv_s;
  assign read_en = irst_s & ~oe_n_s & we_n_s;

  mfb_rst_qual #(.RST_MIN(RST_MIN)) u_rqual (
    .clk      (clk),
    .rst_n    (rst_n),
    .irst_n_s (irst_s),
    .fire     (rst_fire)
  );

  mfb_addr_latch #(.PW(PIN_AW)) u_alat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rc_s      (rc_s),
    .addr_s    (addr_s),
    .live      (irst_s),
    .clr       (rst_fire),
    .full_addr (arr_addr)
  );

  mfb_wr_port #(.AW(FULL_AW), .DW(DW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_n_s    (we_n_s),
    .oe_n_s    (oe_n_s),
    .live      (irst_s),
    .dq_s      (dq_s),
    .cur_addr  (arr_addr),
    .clr       (rst_fire),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_addr  (cmd_addr)
  );

  mfb_rd_path #(.AW(FULL_AW), .DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_load  (src_load),
    .src_code  (src_code),
    .clr       (rst_fire),
    .read_en   (read_en),
    .cur_addr  (arr_addr),
    .arr_rdata (arr_rdata),
    .stat_data (stat_data),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_abort   <= 1'b0;
      abort_addr <= '0;
    end else begin
      op_abort <= rst_fire & op_busy;
      if (rst_fire && op_busy) abort_addr <= cmd_addr;
    end
  end

endmodule

// File: rtl/mfb_chk.sv
module mfb_chk #(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irst_s,
  input logic          oe_n_s,
  input logic          rst_fire,
  input logic          dq_oe,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [DW-1:0] cmd_data,
  input logic [AW-1:0] cmd_addr,
  input logic [AW-1:0] arr_addr,
  input logic          op_busy,
  input logic          op_abort
);

  // R4
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irst_s |=> !dq_oe);

  // R3
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_s |=> !dq_oe);

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !rst_fire) |=>
      (cmd_valid && $stable(cmd_data) && $stable(cmd_addr)));

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> (!cmd_valid && (arr_addr == '0)));

  // R11
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |=> !op_abort);

  // R11
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> ($past(rst_fire) && $past(op_busy)));

endmodule

bind mux_flash_front mfb_chk #(.AW(FULL_AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irst_s    (irst_s),
  .oe_n_s    (oe_n_s),
  .rst_fire  (rst_fire),
  .dq_oe     (dq_oe),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data),
  .cmd_addr  (cmd_addr),
  .arr_addr  (arr_addr),
  .op_busy   (op_busy),
  .op_abort  (op_abort)
);

// File: tb/test_mux_flash_front.sv
`timescale 1ns/1ps
module test_mux_flash_front;

  localparam int RST_MIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] p_addr = '0;
  logic        p_rc = 1'b1, p_oe_n = 1'b1, p_we_n = 1'b1, p_irst_n = 1'b1;
  logic [7:0]  p_dq = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_data;
  logic [21:0] cmd_addr;
  logic        src_load = 1'b0;
  logic [1:0]  src_code = '0;
  logic [21:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic [7:0]  stat_data = 8'h00;
  logic        op_busy = 1'b0;
  logic        op_abort;
  logic [21:0] abort_addr;

  int checks = 0, failures = 0, ab_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arr_byte(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  assign arr_rdata = arr_byte(arr_addr);

  mux_flash_front i_mux_flash_front (
    .clk(clk), .rst_n(rst_n), .pin_addr(p_addr), .pin_rc(p_rc),
    .pin_oe_n(p_oe_n), .pin_we_n(p_we_n), .pin_ifc_rst_n(p_irst_n),
    .dq_i(p_dq), .dq_o(dq_o), .dq_oe(dq_oe), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
    .src_load(src_load), .src_code(src_code), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .stat_data(stat_data), .op_busy(op_busy),
    .op_abort(op_abort), .abort_addr(abort_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // pin vector: irst[0] we_n[1] oe_n[2] rc[3] dq[11:4] addr[22:12]
  localparam logic [22:0] IDLE = 23'h00000F;
  logic [22:0] pv;
  assign pv = {p_addr, p_dq, p_rc, p_oe_n, p_we_n, p_irst_n};

  logic [22:0] m_s0, m_s1, m_q;
  int          m_cnt;
  logic [10:0] m_row, m_col;
  logic [1:0]  m_sel;
  logic        m_cv, m_oe, m_ab;
  logic [7:0]  m_cd, m_do;
  logic [21:0] m_ca, m_aa;

  always @(posedge clk) begin : ref_model
    logic [22:0] s, q;
    logic [21:0] fa;
    logic [7:0]  b;
    logic        fire, rd, wr;
    if (!rst_n) begin
      m_s0 = IDLE; m_s1 = IDLE; m_q = IDLE; m_cnt = 0;
      m_row = '0; m_col = '0; m_sel = 2'd0; m_cv = 0; m_oe = 0; m_ab = 0;
      m_cd = '0; m_do = '0; m_ca = '0; m_aa = '0;
    end else begin
      s = m_s1; q = m_q; fa = {m_col, m_row};
      fire = 0;
      if (!s[0]) begin
        if (m_cnt + 1 == RST_MIN) fire = 1;
        if (m_cnt < RST_MIN) m_cnt = m_cnt + 1;
      end else m_cnt = 0;
      rd = s[0] && !s[2] && s[1];
      case (m_sel)
        2'd1: b = stat_data;
        2'd2: b = fa[1] ? 8'h00 : (fa[0] ? 8'h29 : 8'h20);
        default: b = arr_byte(fa);
      endcase
      m_oe = rd;
      m_do = rd ? b : 8'h00;
      m_ab = fire && op_busy;
      if (fire && op_busy) m_aa = m_ca;
      wr = !q[1] && s[1] && s[2] && s[0];
      if (fire) m_cv = 0;
      else if (wr && (!m_cv || cmd_ready)) begin
        m_cv = 1; m_cd = s[11:4]; m_ca = fa;
      end else if (cmd_ready) m_cv = 0;
      if (fire) begin m_row = '0; m_col = '0; end
      else if (s[0]) begin
        if (q[3] && !s[3]) m_row = s[22:12];
        if (!q[3] && s[3]) m_col = s[22:12];
      end
      if (fire) m_sel = 2'd0;
      else if (src_load && src_code != 2'd3) m_sel = src_code;
      m_q = m_s1; m_s1 = m_s0; m_s0 = pv;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (op_abort) ab_cnt++;
      chk(dq_oe == m_oe, "R2 dq_oe model", 32'(dq_oe), 32'(m_oe));
      chk(dq_o == m_do, "R2 dq_o model", 32'(dq_o), 32'(m_do));
      chk(arr_addr == {m_col, m_row}, "R1 arr_addr model", 32'(arr_addr), 32'({m_col, m_row}));
      chk(cmd_valid == m_cv, "R5 cmd_valid model", 32'(cmd_valid), 32'(m_cv));
      if (m_cv) begin
        chk(cmd_data == m_cd, "R5 cmd_data model", 32'(cmd_data), 32'(m_cd));
        chk(cmd_addr == m_ca, "R5 cmd_addr model", 32'(cmd_addr), 32'(m_ca));
      end
      chk(op_abort == m_ab, "R11 op_abort model", 32'(op_abort), 32'(m_ab));
      chk(abort_addr == m_aa, "R11 abort_addr model", 32'(abort_addr), 32'(m_aa));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [21:0] a);
    p_addr = a[10:0];  tick(1);
    p_rc = 1'b0;       tick(1);
    p_addr = a[21:11]; tick(1);
    p_rc = 1'b1;       tick(4);
  endtask

  task automatic read_at(input logic [21:0] a, output logic [7:0] d,
                         output logic en);
    set_addr(a);
    p_oe_n = 1'b0; tick(5);
    d = dq_o; en = dq_oe;
    p_oe_n = 1'b1; tick(4);
  endtask

  task automatic write_at(input logic [21:0] a, input logic [7:0] d);
    set_addr(a);
    p_dq = d;      tick(1);
    p_we_n = 1'b0; tick(2);
    p_we_n = 1'b1; tick(5);
  endtask

  task automatic load_src(input logic [1:0] c);
    src_code = c; src_load = 1'b1; tick(1);
    src_load = 1'b0; tick(1);
  endtask

  task automatic pulse_rst(input int n);
    p_irst_n = 1'b0; tick(n);
    p_irst_n = 1'b1; tick(5);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [21:0] a1, a2, a3, a4;
    logic [7:0]  d;
    logic        en;
    a1 = {11'h13C, 11'h2A5};
    a2 = {11'h055, 11'h3F0};
    a3 = {11'h7FF, 11'h001};
    a4 = {11'h222, 11'h444};

    tick(4); rst_n = 1'b1; tick(3);
    // reset state (R7 default checked by first read)
    chk(dq_oe == 1'b0, "R3 reset dq_oe", 32'(dq_oe), 0);
    chk(cmd_valid == 1'b0, "R5 reset cmd_valid", 32'(cmd_valid), 0);
    chk(arr_addr == '0, "R1 reset arr_addr", 32'(arr_addr), 0);
    chk(op_abort == 1'b0, "R11 reset op_abort", 32'(op_abort), 0);

    set_addr(a1);
    chk(arr_addr == a1, "R1 row/column join", 32'(arr_addr), 32'(a1));

    p_oe_n = 1'b0; tick(5);
    chk(dq_oe == 1'b1, "R2 read drives", 32'(dq_oe), 1);
    chk(dq_o == arr_byte(a1), "R7 default array source", 32'(dq_o), 32'(arr_byte(a1)));
    p_we_n = 1'b0; tick(5);
    chk(dq_oe == 1'b0, "R3 oe and we both low", 32'(dq_oe), 0);
    p_we_n = 1'b1; tick(5);
    chk(cmd_valid == 1'b0, "R5 write with oe low ignored", 32'(cmd_valid), 0);
    p_oe_n = 1'b1; tick(5);
    chk(dq_oe == 1'b0, "R3 oe high disables", 32'(dq_oe), 0);
    chk(dq_o == 8'h00, "R3 dq_o quiet", 32'(dq_o), 0);

    p_oe_n = 1'b0; p_irst_n = 1'b0; tick(4);
    chk(dq_oe == 1'b0, "R4 interface reset disables", 32'(dq_oe), 0);
    p_irst_n = 1'b1; tick(5);
    chk(dq_oe == 1'b1, "R9 short reset read resumes", 32'(dq_oe), 1);
    p_oe_n = 1'b1; tick(4);

    stat_data = 8'hC3;
    load_src(2'd1);
    read_at(a1, d, en);
    chk(d == 8'hC3, "R7 status source", 32'(d), 32'hC3);
    pulse_rst(3);
    chk(arr_addr == a1, "R9 short reset keeps address", 32'(arr_addr), 32'(a1));
    read_at(a1, d, en);
    chk(d == 8'hC3, "R9 short reset keeps source", 32'(d), 32'hC3);

    load_src(2'd2);
    read_at(22'h000004, d, en);
    chk(d == 8'h20, "R8 maker byte", 32'(d), 32'h20);
    read_at(22'h000005, d, en);
    chk(d == 8'h29, "R8 device byte", 32'(d), 32'h29);
    read_at(22'h000006, d, en);
    chk(d == 8'h00, "R8 unprotected", 32'(d), 32'h00);
    load_src(2'd3);
    read_at(22'h000005, d, en);
    chk(d == 8'h29, "R7 code 3 ignored", 32'(d), 32'h29);

    cmd_ready = 1'b0;
    write_at(a2, 8'h40);
    chk(cmd_valid == 1'b1, "R5 write valid", 32'(cmd_valid), 1);
    chk(cmd_data == 8'h40, "R5 write data", 32'(cmd_data), 32'h40);
    chk(cmd_addr == a2, "R5 write address", 32'(cmd_addr), 32'(a2));
    write_at(a3, 8'h90);
    chk(cmd_data == 8'h40, "R6 overrun dropped data", 32'(cmd_data), 32'h40);
    chk(cmd_addr == a2, "R6 overrun dropped addr", 32'(cmd_addr), 32'(a2));
    cmd_ready = 1'b1; tick(1);
    cmd_ready = 1'b0;
    chk(cmd_valid == 1'b0, "R6 handshake empties", 32'(cmd_valid), 0);
    cmd_ready = 1'b1;
    write_at(a3, 8'h91);
    cmd_ready = 1'b0;

    write_at(a4, 8'h20);
    op_busy = 1'b1; ab_cnt = 0;
    pulse_rst(RST_MIN + 2);
    op_busy = 1'b0;
    chk(ab_cnt == 1, "R11 single abort pulse", 32'(ab_cnt), 1);
    chk(abort_addr == a4, "R11 abort address", 32'(abort_addr), 32'(a4));
    chk(cmd_valid == 1'b0, "R10 pending dropped", 32'(cmd_valid), 0);
    chk(arr_addr == '0, "R10 address cleared", 32'(arr_addr), 0);
    read_at(22'h000000, d, en);
    chk(d == 8'h5A, "R10 source back to array", 32'(d), 32'h5A);

    ab_cnt = 0;
    pulse_rst(RST_MIN + 2);
    chk(ab_cnt == 0, "R11 no abort when idle", 32'(ab_cnt), 0);

    tick(3);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule